// File: doc/BRIEF.md
# Parallel flash command interpreter

This block models a parallel NOR-style flash device as seen from a simple synchronous bus. The device holds a small word-wide storage array divided into equal sectors. A host changes or inspects it by writing command codes on the low data byte. Some commands take effect in one write. Others open a short sequence of further writes: word program, sector erase with confirm, buffered write with a count and a confirm, and lock setup with a confirm. A sticky status register records completion and error flags. A read-only input turns every modification into an error flag and leaves the storage unchanged.

The last accepted command sets the read mode. A read can return array data, the status register, one of two identifier words or a byte from a query table. The query table is supplied as a parameter. For identifier and query reads, the low byte of the byte address is divided by the bus width in bytes to form the index. Read data is registered. It appears one clock after the read strobe and holds until the next strobe. A read and a write in the same cycle see the state from before the write.

Top module: `nor_flash_ctl`

## Requirements
- R1: After reset the status register is 0x00, no command is pending, read data is zero, and every storage word reads as all ones in array mode.
- R2: A read strobe in cycle n puts the selected value on read data after the clock edge that ends cycle n. Without a strobe, read data keeps its value.
- R3: With no sequence open, a write of 0x00, 0xFF or any code not listed in R4 to R10 leaves the device in array-read mode with no sequence open.
- R4: With no sequence open, a write of 0x50 clears the status register to 0x00 and selects array-read mode at once.
- R5: A write of 0x70 selects status reads and a write of 0x90 selects identifier reads, with no further write needed. In identifier mode, index 0 returns the manufacturer code, index 1 returns the device code and any other index returns zero. The index is the low address byte shifted right by log2 of the bus width in bytes.
- R6: A write of 0x10 or 0x40 arms a program. The next write stores its full data word at its address and sets status bit 7. With read-only set, that write stores nothing and sets status bit 4 as well as bit 7. The sequence then closes.
- R7: A write of 0x20 fills, in the same write, every word of the sector holding the address with all ones and sets status bit 7. Other sectors are untouched. With read-only set, nothing is erased and status bit 5 is set as well as bit 7. The next write closes the sequence: 0xD0 keeps status reads, and 0xFF or any other value returns to array-read mode.
- R8: A write of 0xE8 sets status bit 7 and opens a buffered write. The next write gives a count N on its low 8 bits. The following N+1 writes each store data as in R6, including the read-only rule. A write of 0xD0 then closes the sequence with status reads. Any other value at that point returns to array-read mode.
- R9: A write of 0x60 opens lock setup. A following 0xD0 or 0x01 sets status bit 7 and keeps status reads. Any other following value returns to array-read mode.
- R10: A write of 0x98 selects query reads. A read returns the table byte at the index of R5, zero-extended, or zero when the index is not below the table length. In this mode a write of 0xFF returns to array-read mode and any other write leaves query mode in place.
- R11: Status reads are selected while the last retained command is 0x10, 0x20, 0x40, 0x60, 0x70 or 0xE8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| read_only | input | 1 | When high, program and erase requests only set error flags |
| addr | input | ADDR_W | Byte address for reads and writes |
| wr_en | input | 1 | Write strobe for one cycle; data is a command or a data word |
| wdata | input | DATA_W | Write data; command codes use the low byte |
| rd_en | input | 1 | Read strobe for one cycle |
| rdata | output | DATA_W | Registered read data |

## Verification
The bench builds the block with a 16-bit bus, 64 storage words in four 16-word sectors and a 24-entry query table of its own. It also supplies its own identifier codes. The 16-bit width makes the index shift of R5 and R10 visible. The four sectors let an erase be shown to leave the neighbouring sectors alone. The short table, inside a 7-bit address space, lets reads beyond the table end return zero. The read-only input is raised in the middle of the run, so the error flags and the untouched storage can be checked against a shadow copy.

// File: rtl/nfc_pkg.sv
package nfc_pkg;

    typedef enum logic [1:0] {
        CYC_IDLE    = 2'd0,
        CYC_ARG     = 2'd1,
        CYC_DATA    = 2'd2,
        CYC_CONFIRM = 2'd3
    } cyc_t;

    typedef enum logic [1:0] {
        RD_ARRAY  = 2'd0,
        RD_STATUS = 2'd1,
        RD_IDENT  = 2'd2,
        RD_QUERY  = 2'd3
    } rdsel_t;

    typedef struct packed {
        logic prog;
        logic erase;
    } arr_op_t;

    localparam logic [7:0] OP_NOP      = 8'h00;
    localparam logic [7:0] OP_ARRAY    = 8'hFF;
    localparam logic [7:0] OP_PROG_A   = 8'h10;
    localparam logic [7:0] OP_PROG_B   = 8'h40;
    localparam logic [7:0] OP_ERASE    = 8'h20;
    localparam logic [7:0] OP_CLR      = 8'h50;
    localparam logic [7:0] OP_LOCK     = 8'h60;
    localparam logic [7:0] OP_STAT     = 8'h70;
    localparam logic [7:0] OP_IDENT    = 8'h90;
    localparam logic [7:0] OP_QUERY    = 8'h98;
    localparam logic [7:0] OP_BUF      = 8'hE8;
    localparam logic [7:0] OP_CONFIRM  = 8'hD0;
    localparam logic [7:0] OP_LOCK_ALT = 8'h01;

    localparam int ST_READY     = 7;
    localparam int ST_ERASE_ERR = 5;
    localparam int ST_PROG_ERR  = 4;

    function automatic rdsel_t read_sel(input logic [7:0] c);
        rdsel_t s;
        case (c)
            OP_IDENT: s = RD_IDENT;
            OP_QUERY: s = RD_QUERY;
            OP_PROG_A, OP_PROG_B, OP_ERASE, OP_CLR,
            OP_LOCK, OP_STAT, OP_BUF: s = RD_STATUS;
            default: s = RD_ARRAY;
        endcase
        return s;
    endfunction

    function automatic logic [7:0] flag(input int pos);
        return 8'(1) << pos;
    endfunction

endpackage

// File: rtl/nfc_seq.sv
module nfc_seq
    import nfc_pkg::*;
#(
    parameter int COUNT_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               read_only,
    input  logic               wr_en,
    input  logic [7:0]         wbyte,
    input  logic [COUNT_W-1:0] wcount,
    output arr_op_t            op,
    output cyc_t               cyc_q,
    output logic [7:0]         cmd_q,
    output logic [7:0]         status_q
);

    cyc_t               cyc_d;
    logic [7:0]         cmd_d;
    logic [7:0]         status_d;
    logic [COUNT_W-1:0] cnt_q;
    logic [COUNT_W-1:0] cnt_d;
    logic               to_array;

    always_comb begin
        cyc_d    = cyc_q;
        cmd_d    = cmd_q;
        status_d = status_q;
        cnt_d    = cnt_q;
        op       = '0;
        to_array = 1'b0;
        if (wr_en) begin
            case (cyc_q)
                CYC_IDLE: begin
                    case (wbyte)
                        OP_NOP, OP_ARRAY: to_array = 1'b1;
                        OP_PROG_A, OP_PROG_B, OP_LOCK, OP_QUERY: begin
                            cyc_d = CYC_ARG;
                            cmd_d = wbyte;
                        end
                        OP_ERASE: begin
                            op.erase = !read_only;
                            status_d = status_q | flag(ST_READY)
                                     | (read_only ? flag(ST_ERASE_ERR) : 8'h00);
                            cyc_d    = CYC_ARG;
                            cmd_d    = wbyte;
                        end
                        OP_CLR: begin
                            status_d = 8'h00;
                            to_array = 1'b1;
                        end
                        OP_STAT, OP_IDENT: cmd_d = wbyte;
                        OP_BUF: begin
                            status_d = status_q | flag(ST_READY);
                            cyc_d    = CYC_ARG;
                            cmd_d    = wbyte;
                        end
                        default: to_array = 1'b1;
                    endcase
                end
                CYC_ARG: begin
                    case (cmd_q)
                        OP_PROG_A, OP_PROG_B: begin
                            op.prog  = !read_only;
                            status_d = status_q | flag(ST_READY)
                                     | (read_only ? flag(ST_PROG_ERR) : 8'h00);
                            cyc_d    = CYC_IDLE;
                        end
                        OP_ERASE: begin
                            if (wbyte == OP_CONFIRM) cyc_d = CYC_IDLE;
                            else                     to_array = 1'b1;
                        end
                        OP_BUF: begin
                            cnt_d = wcount;
                            cyc_d = CYC_DATA;
                        end
                        OP_LOCK: begin
                            if (wbyte == OP_CONFIRM || wbyte == OP_LOCK_ALT) begin
                                status_d = status_q | flag(ST_READY);
                                cyc_d    = CYC_IDLE;
                            end else begin
                                to_array = 1'b1;
                            end
                        end
                        OP_QUERY: begin
                            if (wbyte == OP_ARRAY) to_array = 1'b1;
                        end
                        default: to_array = 1'b1;
                    endcase
                end
                CYC_DATA: begin
                    op.prog  = !read_only;
                    status_d = status_q | flag(ST_READY)
                             | (read_only ? flag(ST_PROG_ERR) : 8'h00);
                    if (cnt_q == '0) cyc_d = CYC_CONFIRM;
                    cnt_d = cnt_q - 1'b1;
                end
                CYC_CONFIRM: begin
                    if (wbyte == OP_CONFIRM) begin
                        status_d = status_q | flag(ST_READY);
                        cyc_d    = CYC_IDLE;
                    end else begin
                        to_array = 1'b1;
                    end
                end
                default: to_array = 1'b1;
            endcase
            if (to_array) begin
                cyc_d = CYC_IDLE;
                cmd_d = OP_NOP;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cyc_q    <= CYC_IDLE;
            cmd_q    <= OP_NOP;
            status_q <= 8'h00;
            cnt_q    <= '0;
        end else begin
            cyc_q    <= cyc_d;
            cmd_q    <= cmd_d;
            status_q <= status_d;
            cnt_q    <= cnt_d;
        end
    end

endmodule

// File: rtl/nfc_array.sv
module nfc_array
    import nfc_pkg::*;
#(
    parameter int DATA_W       = 16,
    parameter int WORDS        = 64,
    parameter int SECTOR_WORDS = 16,
    localparam int IDX_W       = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst,
    input  arr_op_t           op,
    input  logic [IDX_W-1:0]  widx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rword
);

    localparam int SEC_SH = $clog2(SECTOR_WORDS);

    logic [DATA_W-1:0] words [WORDS];

    for (genvar g = 0; g < WORDS; g++) begin : g_word
        localparam logic [IDX_W-1:0] GI = IDX_W'(g);
        logic              in_sector;
        logic [DATA_W-1:0] word_q;

        assign in_sector = (GI >> SEC_SH) == (widx >> SEC_SH);

        always_ff @(posedge clk) begin
            if (rst) begin
                word_q <= '1;
            end else if (op.erase && in_sector) begin
                word_q <= '1;
            end else if (op.prog && widx == GI) begin
                word_q <= wdata;
            end
        end

        assign words[g] = word_q;
    end

    assign rword = words[widx];

endmodule

// File: rtl/nfc_rdmux.sv
module nfc_rdmux
    import nfc_pkg::*;
#(
    parameter int                  DATA_W    = 16,
    parameter int                  QRY_LEN   = 24,
    parameter logic [QRY_LEN*8-1:0] QRY_TABLE = '0,
    parameter logic [DATA_W-1:0]   MFR_CODE  = '0,
    parameter logic [DATA_W-1:0]   DEV_CODE  = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  rdsel_t            sel,
    input  logic [7:0]        idx,
    input  logic [7:0]        status,
    input  logic [DATA_W-1:0] rword,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] rnext;
    logic [7:0]        qbyte;

    always_comb begin
        qbyte = 8'h00;
        for (int i = 0; i < QRY_LEN; i++) begin
            if (int'(idx) == i) qbyte = QRY_TABLE[i*8 +: 8];
        end
    end

    always_comb begin
        case (sel)
            RD_STATUS: rnext = DATA_W'(status);
            RD_IDENT: begin
                if (idx == 8'd0)      rnext = MFR_CODE;
                else if (idx == 8'd1) rnext = DEV_CODE;
                else                  rnext = '0;
            end
            RD_QUERY: rnext = DATA_W'(qbyte);
            default:  rnext = rword;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)        rdata <= '0;
        else if (rd_en) rdata <= rnext;
    end

endmodule

// File: rtl/nor_flash_ctl.sv
module nor_flash_ctl
    import nfc_pkg::*;
#(
    parameter int                   DATA_W       = 16,
    parameter int                   WORDS        = 64,
    parameter int                   SECTOR_WORDS = 16,
    parameter int                   COUNT_W      = 8,
    parameter int                   QRY_LEN      = 24,
    parameter logic [QRY_LEN*8-1:0] QRY_TABLE    = '0,
    parameter logic [DATA_W-1:0]    MFR_CODE     = DATA_W'(16'h0089),
    parameter logic [DATA_W-1:0]    DEV_CODE     = DATA_W'(16'h0018),
    localparam int                  SHIFT        = $clog2(DATA_W / 8),
    localparam int                  IDX_W        = $clog2(WORDS),
    localparam int                  ADDR_W       = IDX_W + SHIFT
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              read_only,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rdata
);

    arr_op_t           op;
    cyc_t              cyc_q;
    logic [7:0]        cmd_q;
    logic [7:0]        status_q;
    logic [DATA_W-1:0] rword;
    logic [IDX_W-1:0]  widx;
    logic [7:0]        idx;
    logic              arr_prog;
    logic              arr_erase;

    assign widx      = addr[ADDR_W-1:SHIFT];
    assign idx       = 8'(addr) >> SHIFT;
    assign arr_prog  = op.prog;
    assign arr_erase = op.erase;

    nfc_seq #(.COUNT_W(COUNT_W)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .read_only(read_only),
        .wr_en    (wr_en),
        .wbyte    (wdata[7:0]),
        .wcount   (wdata[COUNT_W-1:0]),
        .op       (op),
        .cyc_q    (cyc_q),
        .cmd_q    (cmd_q),
        .status_q (status_q)
    );

    nfc_array #(
        .DATA_W      (DATA_W),
        .WORDS       (WORDS),
        .SECTOR_WORDS(SECTOR_WORDS)
    ) u_array (
        .clk  (clk),
        .rst  (rst),
        .op   (op),
        .widx (widx),
        .wdata(wdata),
        .rword(rword)
    );

    nfc_rdmux #(
        .DATA_W   (DATA_W),
        .QRY_LEN  (QRY_LEN),
        .QRY_TABLE(QRY_TABLE),
        .MFR_CODE (MFR_CODE),
        .DEV_CODE (DEV_CODE)
    ) u_rdmux (
        .clk   (clk),
        .rst   (rst),
        .rd_en (rd_en),
        .sel   (read_sel(cmd_q)),
        .idx   (idx),
        .status(status_q),
        .rword (rword),
        .rdata (rdata)
    );

endmodule

// File: rtl/nor_flash_ctl_chk.sv
module nor_flash_ctl_chk
    import nfc_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              read_only,
    input logic              wr_en,
    input logic              rd_en,
    input logic [DATA_W-1:0] wdata,
    input logic [DATA_W-1:0] rdata,
    input cyc_t              cyc,
    input logic [7:0]        cmd,
    input logic [7:0]        status,
    input logic              prog,
    input logic              erase
);

    logic idle_wr;
    logic arg_wr;
    assign idle_wr = wr_en && cyc == CYC_IDLE;
    assign arg_wr  = wr_en && cyc == CYC_ARG;

    assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (status == 8'h00 && cmd == OP_NOP && cyc == CYC_IDLE && rdata == '0));

    assert_read_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rdata));

    assert_array_cmd_R3: assert property (@(posedge clk) disable iff (rst)
        (idle_wr && wdata[7:0] == OP_ARRAY) |=> (cmd == OP_NOP && cyc == CYC_IDLE));

    assert_clear_R4: assert property (@(posedge clk) disable iff (rst)
        (idle_wr && wdata[7:0] == OP_CLR) |=> (status == 8'h00 && cmd == OP_NOP));

    assert_prog_done_R6: assert property (@(posedge clk) disable iff (rst)
        (arg_wr && (cmd == OP_PROG_A || cmd == OP_PROG_B)) |=> (status[ST_READY] && cyc == CYC_IDLE));

    assert_prog_ro_R6: assert property (@(posedge clk) disable iff (rst)
        (arg_wr && (cmd == OP_PROG_A || cmd == OP_PROG_B) && read_only) |=> status[ST_PROG_ERR]);

    assert_erase_ro_R7: assert property (@(posedge clk) disable iff (rst)
        (idle_wr && wdata[7:0] == OP_ERASE && read_only) |=> (status[ST_ERASE_ERR] && status[ST_READY]));

    assert_single_op_R7: assert property (@(posedge clk) disable iff (rst)
        $onehot0({prog, erase}));

    assert_buf_reject_R8: assert property (@(posedge clk) disable iff (rst)
        (wr_en && cyc == CYC_CONFIRM && wdata[7:0] != OP_CONFIRM) |=> (cyc == CYC_IDLE && cmd == OP_NOP));

    assert_lock_done_R9: assert property (@(posedge clk) disable iff (rst)
        (arg_wr && cmd == OP_LOCK && (wdata[7:0] == OP_CONFIRM || wdata[7:0] == OP_LOCK_ALT))
        |=> (status[ST_READY] && cyc == CYC_IDLE && cmd == OP_LOCK));

    assert_query_stay_R10: assert property (@(posedge clk) disable iff (rst)
        (arg_wr && cmd == OP_QUERY && wdata[7:0] != OP_ARRAY) |=> cmd == OP_QUERY);

endmodule

bind nor_flash_ctl nor_flash_ctl_chk #(.DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .read_only(read_only),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .wdata    (wdata),
    .rdata    (rdata),
    .cyc      (cyc_q),
    .cmd      (cmd_q),
    .status   (status_q),
    .prog     (arr_prog),
    .erase    (arr_erase)
);

// File: tb/nor_flash_ctl_test.sv
`timescale 1ns/1ps
module nor_flash_ctl_test;

    localparam int DW = 16;
    localparam int NW = 64;
    localparam int SW = 16;
    localparam int QL = 24;
    localparam int AW = 7;
    localparam logic [15:0] MFR = 16'h00A7;
    localparam logic [15:0] DEV = 16'h5C21;

    function automatic logic [7:0] tab_byte(input int i);
        return 8'((i * 37 + 5) & 255);
    endfunction

    function automatic logic [QL*8-1:0] mk_tab();
        logic [QL*8-1:0] t;
        t = '0;
        for (int i = 0; i < QL; i++) t[i*8 +: 8] = tab_byte(i);
        return t;
    endfunction

    localparam logic [QL*8-1:0] TAB = mk_tab();

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ro = 1'b0;
    logic          wr_en = 1'b0;
    logic          rd_en = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    wire  [DW-1:0] rdata;

    int    n_tests = 0;
    int    n_fail = 0;
    string cur_req = "R1";
    bit    checking = 1'b0;
    bit    done = 1'b0;

    always #4 clk = ~clk;

    nor_flash_ctl #(
        .DATA_W      (DW),
        .WORDS       (NW),
        .SECTOR_WORDS(SW),
        .COUNT_W     (8),
        .QRY_LEN     (QL),
        .QRY_TABLE   (TAB),
        .MFR_CODE    (MFR),
        .DEV_CODE    (DEV)
    ) uut (
        .clk      (clk),
        .rst      (rst),
        .read_only(ro),
        .addr     (addr),
        .wr_en    (wr_en),
        .wdata    (wdata),
        .rd_en    (rd_en),
        .rdata    (rdata)
    );

    // reference model state
    int          m_cyc;
    int          m_cnt;
    logic [7:0]  m_cmd;
    logic [7:0]  m_st;
    logic [15:0] shadow [NW];
    logic [15:0] exp_q = '0;

    function automatic logic [15:0] model_read(input int a);
        int w;
        int ix;
        w  = a / 2;
        ix = (a & 255) / 2;
        case (m_cmd)
            8'h00: return shadow[w];
            8'h10, 8'h20, 8'h40, 8'h60, 8'h70, 8'hE8: return {8'h00, m_st};
            8'h90: return (ix == 0) ? MFR : ((ix == 1) ? DEV : 16'h0000);
            8'h98: return (ix < QL) ? {8'h00, tab_byte(ix)} : 16'h0000;
            default: return shadow[w];
        endcase
    endfunction

    task automatic m_to_array();
        m_cyc = 0;
        m_cmd = 8'h00;
    endtask

    task automatic m_store(input int a, input logic [15:0] d);
        if (ro) m_st = m_st | 8'h10;
        else    shadow[a / 2] = d;
        m_st = m_st | 8'h80;
    endtask

    task automatic model_write(input int a, input logic [15:0] d);
        logic [7:0] c;
        int base;
        c = d[7:0];
        case (m_cyc)
            0: begin
                if (c == 8'h00 || c == 8'hFF) m_to_array();
                else if (c == 8'h10 || c == 8'h40 || c == 8'h60 || c == 8'h98) begin
                    m_cyc = 1; m_cmd = c;
                end else if (c == 8'h20) begin
                    if (ro) m_st = m_st | 8'h20;
                    else begin
                        base = ((a / 2) / SW) * SW;
                        for (int k = 0; k < SW; k++) shadow[base + k] = 16'hFFFF;
                    end
                    m_st = m_st | 8'h80;
                    m_cyc = 1; m_cmd = c;
                end else if (c == 8'h50) begin
                    m_st = 8'h00; m_to_array();
                end else if (c == 8'h70 || c == 8'h90) begin
                    m_cmd = c;
                end else if (c == 8'hE8) begin
                    m_st = m_st | 8'h80; m_cyc = 1; m_cmd = c;
                end else m_to_array();
            end
            1: begin
                if (m_cmd == 8'h10 || m_cmd == 8'h40) begin
                    m_store(a, d); m_cyc = 0;
                end else if (m_cmd == 8'h20) begin
                    if (c == 8'hD0) m_cyc = 0; else m_to_array();
                end else if (m_cmd == 8'hE8) begin
                    m_cnt = int'(c); m_cyc = 2;
                end else if (m_cmd == 8'h60) begin
                    if (c == 8'hD0 || c == 8'h01) begin
                        m_st = m_st | 8'h80; m_cyc = 0;
                    end else m_to_array();
                end else if (m_cmd == 8'h98) begin
                    if (c == 8'hFF) m_to_array();
                end else m_to_array();
            end
            2: begin
                m_store(a, d);
                if (m_cnt == 0) m_cyc = 3;
                m_cnt = (m_cnt - 1) & 255;
            end
            default: begin
                if (c == 8'hD0) begin
                    m_st = m_st | 8'h80; m_cyc = 0;
                end else m_to_array();
            end
        endcase
    endtask

    always @(posedge clk) begin
        if (rst) begin
            m_cyc = 0; m_cnt = 0; m_cmd = 8'h00; m_st = 8'h00; exp_q = 16'h0000;
            for (int i = 0; i < NW; i++) shadow[i] = 16'hFFFF;
        end else begin
            if (rd_en) exp_q = model_read(int'(addr));
            if (wr_en) model_write(int'(addr), wdata);
        end
    end

    always @(negedge clk) begin
        if (checking && !done) begin
            n_tests++;
            if (rdata !== exp_q) begin
                n_fail++;
                $display("FAIL %s: rdata=%h expected=%h at %0t", cur_req, rdata, exp_q, $time);
            end
        end
    end

    task automatic wr(input int a, input logic [15:0] d);
        @(negedge clk);
        addr = AW'(a); wdata = d; wr_en = 1'b1; rd_en = 1'b0;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int a);
        @(negedge clk);
        addr = AW'(a); rd_en = 1'b1; wr_en = 1'b0;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic gap(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #800000;
        if (!done) begin
            done = 1'b1;
            n_fail++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        repeat (3) @(negedge clk);
        #1 rst = 1'b0;
        checking = 1'b1;

        cur_req = "R1";
        gap(2);
        rd(0); rd(126); gap(1);

        cur_req = "R2";
        rd(10); gap(3);

        cur_req = "R5";
        wr(0, 16'h0090);
        rd(0); rd(1); rd(2); rd(3); rd(4); rd(40);
        wr(0, 16'h00FF); rd(0);
        wr(0, 16'h0070); rd(8);

        cur_req = "R10";
        wr(0, 16'h0098);
        for (int ix = 0; ix < 34; ix++) rd(ix * 2);
        rd(127);
        wr(6, 16'h0055); rd(34); rd(46); rd(48);
        wr(0, 16'h00FF); rd(34);

        cur_req = "R6";
        wr(20, 16'h0040); wr(20, 16'h1234); rd(20);
        wr(0, 16'h00FF); rd(20);
        wr(22, 16'h0010); wr(22, 16'hBEEF); rd(22);
        wr(0, 16'h0000); rd(22);

        cur_req = "R11";
        wr(0, 16'h0070); rd(22);

        cur_req = "R4";
        wr(0, 16'h0050); rd(20);
        wr(0, 16'h0070); rd(20);
        wr(0, 16'h00FF);

        cur_req = "R7";
        wr(34, 16'h0040); wr(34, 16'hA5A5);
        wr(0, 16'h00FF);
        wr(66, 16'h0040); wr(66, 16'h5A5A);
        wr(0, 16'h0050);
        wr(44, 16'h0020); rd(44);
        wr(44, 16'h00D0); rd(44);
        wr(0, 16'h00FF);
        rd(34); rd(32); rd(62); rd(66); rd(20);
        wr(100, 16'h0020); wr(100, 16'h00FF); rd(66);
        wr(10, 16'h0020); wr(10, 16'h0033); rd(20);

        cur_req = "R8";
        wr(0, 16'h0050);
        wr(70, 16'h00E8); rd(70);
        wr(70, 16'h0003);
        wr(70, 16'h1111); wr(72, 16'h2222); wr(74, 16'h3333); wr(76, 16'h4444);
        rd(70);
        wr(70, 16'h00D0); rd(70);
        wr(0, 16'h00FF);
        rd(70); rd(72); rd(74); rd(76); rd(78);
        wr(90, 16'h00E8); wr(90, 16'h0000); wr(90, 16'h9999);
        wr(90, 16'h0012); rd(90);

        cur_req = "R9";
        wr(0, 16'h0050);
        wr(0, 16'h0060); wr(0, 16'h00D0); rd(0);
        wr(0, 16'h00FF);
        wr(0, 16'h0050);
        wr(0, 16'h0060); wr(0, 16'h0001); rd(0);
        wr(0, 16'h0060); wr(0, 16'h0077); rd(20);

        cur_req = "R3";
        wr(0, 16'h0070);
        wr(0, 16'h0033); rd(20);
        wr(0, 16'h0070); wr(0, 16'h0000); rd(22);
        wr(0, 16'h0090); wr(0, 16'h00C5); rd(0);

        cur_req = "R6";
        wr(0, 16'h0050);
        @(negedge clk); ro = 1'b1;
        wr(20, 16'h0040); wr(20, 16'h0BAD); rd(20);
        wr(0, 16'h00FF); rd(20);

        cur_req = "R7";
        wr(0, 16'h0050);
        wr(70, 16'h0020); rd(70);
        wr(70, 16'h00D0); wr(0, 16'h00FF); rd(70); rd(72);

        cur_req = "R8";
        wr(0, 16'h0050);
        wr(80, 16'h00E8); wr(80, 16'h0001);
        wr(80, 16'h7777); wr(82, 16'h8888); rd(80);
        wr(80, 16'h00D0); wr(0, 16'h00FF); rd(80); rd(82);
        @(negedge clk); ro = 1'b0;

        cur_req = "R2";
        rd(70); gap(4);

        gap(2);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule